// File: doc/BRIEF.md
# One-Wire Byte Transfer Engine

This block sits beside a one-wire bus master and moves whole bytes instead of single bits. Software writes a byte into the data register. The engine runs eight bit slots on the open-drain bus, least significant bit first. In every slot it also samples the bus level, so the same pass assembles a received byte. To read from a slave, software writes 0xFF, which releases the line in each slot, and then reads the captured byte back from the data register.

A one-byte transmit buffer lets software queue the next byte while the current one is still shifting. Four status flags report the state of the buffers. An enable register selects which flags drive a single level-sensitive interrupt line. Slot timing is fixed by parameters counted in clock cycles: the slot length, the low time for a one or read slot, the low time for a zero slot, and the sample point.

Top module: `ow_byte_engine`

## Requirements
- R1: A write to the data register (address 0) while the transmit buffer is empty is accepted. On the next cycle the status register (address 1) reads bit 2 (transmit buffer empty) = 0 and bit 3 (transmit shift empty) = 0.
- R2: An accepted byte is moved into the shifter one cycle after acceptance, and the bus is driven low from the cycle after that. The byte goes out as eight slots of SLOT_CYC cycles each, least significant bit first. A 1 bit holds the line low for LOW1_CYC cycles and a 0 bit holds it low for LOW0_CYC cycles.
- R3: In each slot the bus level is sampled SAMPLE_CYC cycles after the slot starts. Received bit i is the level seen in slot i. Writing 0xFF therefore returns the slave's byte, and in general the result is the transmitted byte ANDed with the slave's byte.
- R4: When the eighth slot ends, the received byte becomes the value read from address 0, and status bit 4 (receive full) and bit 5 (receive shift ready) are set. Status bit 3 is 1 whenever the shifter is idle and the buffer is empty.
- R5: Reading address 0 with the read strobe clears status bit 4. If a byte completes in the same cycle, the set takes priority.
- R6: Status bit 5 clears when the next byte is moved into the shifter.
- R7: A byte written while another is shifting waits in the buffer, with status bit 2 at 0. It starts after a single idle cycle once the current byte ends.
- R8: A data write while status bit 2 is 0 is ignored, and that byte is never transmitted.
- R9: irq_o is high exactly when any of status bits 2 to 5 is set with the same bit set in the enable register (address 2). The enable register stores only bits 2 to 5 and reads back 0 in every other bit.
- R10: After reset the status register reads 0x0C, the enable register and the received byte read 0, irq_o is low and the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register select: 0 data, 1 status, 2 enable |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (side effect on data register only) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from reg_addr_i |
| ow_low_o | output | 1 | Pull the one-wire line low |
| ow_i | input | 1 | Sensed one-wire line level |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong slot counter or bit index shows up on ow_low_o within one slot: a pulse has the wrong width, or bits come out in the wrong order. A bad sample point or receive shift shows up only at the end of the byte, in the value read back from the data register. A flag that is wrong in the buffer or the interrupt logic is visible on irq_o in the same cycle. For that reason the bench compares ow_low_o and irq_o against a behavioural model on every clock, and it reads the status and data registers at the moments where the flags change.

// File: rtl/ow_byte_pkg.sv
package ow_byte_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_IEN  = 2'd2,
    REG_RSVD = 2'd3
  } ow_reg_e;

  // status bit positions decoded by software
  localparam int ST_TBE  = 2;
  localparam int ST_TSRE = 3;
  localparam int ST_RBF  = 4;
  localparam int ST_RSRF = 5;
  localparam logic [REG_W-1:0] ST_MASK = 8'h3C;
endpackage

// File: rtl/ow_slot_timer.sv
module ow_slot_timer #(
  parameter int SLOT_CYC   = 70,
  parameter int LOW1_CYC   = 6,
  parameter int LOW0_CYC   = 60,
  parameter int SAMPLE_CYC = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic bit_i,
  output logic drive_low_o,
  output logic sample_o,
  output logic slot_end_o
);
  localparam int CW = $clog2(SLOT_CYC);
  localparam logic [CW-1:0] LAST  = CW'(SLOT_CYC - 1);
  localparam logic [CW-1:0] L1    = CW'(LOW1_CYC);
  localparam logic [CW-1:0] L0    = CW'(LOW0_CYC);
  localparam logic [CW-1:0] SMPL  = CW'(SAMPLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign drive_low_o = run_i && (cnt_q < (bit_i ? L1 : L0));
  assign sample_o    = run_i && (cnt_q == SMPL);
  assign slot_end_o  = run_i && (cnt_q == LAST);

  // R3: at the sample point a 0 slot is still held low and a 1 slot is released
  a_r3_low_at_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (drive_low_o == !bit_i));
endmodule

// File: rtl/ow_byte_shifter.sv
module ow_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         sample_i,
  input  logic         bus_i,
  input  logic         slot_end_i,
  output logic         busy_o,
  output logic         tx_bit_o,
  output logic         done_o,
  output logic [W-1:0] rx_byte_o
);
  localparam int IW = $clog2(W);
  localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

  logic          busy_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  tx_q, rx_q;

  assign done_o = slot_end_i && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      if (load_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        tx_q   <= load_data_i;
      end else if (slot_end_i) begin
        tx_q  <= tx_q >> 1;
        idx_q <= idx_q + 1'b1;
        if (done_o) busy_q <= 1'b0;
      end
      if (sample_i) rx_q <= {bus_i, rx_q[W-1:1]};
    end
  end

  assign busy_o    = busy_q;
  assign tx_bit_o  = tx_q[0];
  assign rx_byte_o = rx_q;

  a_r7_load_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
  a_r2_load_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o);
  a_r2_done_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/ow_irq_regs.sv
module ow_irq_regs
  import ow_byte_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [REG_W-1:0] rx_byte_i,
  input  logic             load_i,
  input  logic             rd_data_i,
  input  logic             ien_we_i,
  input  logic [REG_W-1:0] ien_wdata_i,
  input  logic             buf_full_i,
  input  logic             busy_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] ien_o,
  output logic [REG_W-1:0] rx_buf_o,
  output logic             irq_o
);
  logic             rbf_q, rsrf_q;
  logic [REG_W-1:0] ien_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbf_q  <= 1'b0;
      rsrf_q <= 1'b0;
      ien_q  <= '0;
      rx_q   <= '0;
    end else begin
      if (done_i) begin
        rbf_q  <= 1'b1;
        rsrf_q <= 1'b1;
        rx_q   <= rx_byte_i;
      end else begin
        if (rd_data_i) rbf_q  <= 1'b0;
        if (load_i)    rsrf_q <= 1'b0;
      end
      if (ien_we_i) ien_q <= ien_wdata_i;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_TBE]  = !buf_full_i;
    status_o[ST_TSRE] = !buf_full_i && !busy_i;
    status_o[ST_RBF]  = rbf_q;
    status_o[ST_RSRF] = rsrf_q;
  end

  assign ien_o    = ien_q & ST_MASK;
  assign rx_buf_o = rx_q;
  assign irq_o    = |(status_o & ien_o);

  a_r4_done_sets_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (rbf_q && rsrf_q));
  a_r5_read_clears_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && !done_i) |=> !rbf_q);
  a_r6_load_clears_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !rsrf_q);
endmodule

// File: rtl/ow_byte_engine.sv
module ow_byte_engine
  import ow_byte_pkg::*;
#(
  parameter int SLOT_CYC   = 70,
  parameter int LOW1_CYC   = 6,
  parameter int LOW0_CYC   = 60,
  parameter int SAMPLE_CYC = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       reg_addr_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             ow_low_o,
  input  logic             ow_i,
  output logic             irq_o
);
  logic             buf_full_q;
  logic [REG_W-1:0] tx_buf_q;
  logic             wr_data, accept, load, busy, tx_bit;
  logic             sample, slot_end, done;
  logic [REG_W-1:0] rx_byte, status, ien, rx_buf;

  assign wr_data = reg_wr_i && (reg_addr_i == REG_DATA);
  assign accept  = wr_data && !buf_full_q;
  assign load    = buf_full_q && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_full_q <= 1'b0;
      tx_buf_q   <= '0;
    end else if (accept) begin
      buf_full_q <= 1'b1;
      tx_buf_q   <= reg_wdata_i;
    end else if (load) begin
      buf_full_q <= 1'b0;
    end
  end

  ow_slot_timer #(
    .SLOT_CYC(SLOT_CYC), .LOW1_CYC(LOW1_CYC),
    .LOW0_CYC(LOW0_CYC), .SAMPLE_CYC(SAMPLE_CYC)
  ) u_timer (
    .clk_i, .rst_ni,
    .run_i       (busy),
    .bit_i       (tx_bit),
    .drive_low_o (ow_low_o),
    .sample_o    (sample),
    .slot_end_o  (slot_end)
  );

  ow_byte_shifter #(.W(REG_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i      (load),
    .load_data_i (tx_buf_q),
    .sample_i    (sample),
    .bus_i       (ow_i),
    .slot_end_i  (slot_end),
    .busy_o      (busy),
    .tx_bit_o    (tx_bit),
    .done_o      (done),
    .rx_byte_o   (rx_byte)
  );

  ow_irq_regs u_regs (
    .clk_i, .rst_ni,
    .done_i      (done),
    .rx_byte_i   (rx_byte),
    .load_i      (load),
    .rd_data_i   (reg_rd_i && (reg_addr_i == REG_DATA)),
    .ien_we_i    (reg_wr_i && (reg_addr_i == REG_IEN)),
    .ien_wdata_i (reg_wdata_i),
    .buf_full_i  (buf_full_q),
    .busy_i      (busy),
    .status_o    (status),
    .ien_o       (ien),
    .rx_buf_o    (rx_buf),
    .irq_o       (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      REG_DATA: reg_rdata_o = rx_buf;
      REG_STAT: reg_rdata_o = status;
      REG_IEN:  reg_rdata_o = ien;
      default:  reg_rdata_o = '0;
    endcase
  end

  a_r8_full_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && buf_full_q) |=> $stable(tx_buf_q));
  a_r1_accept_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> buf_full_q);
endmodule

// File: tb/ow_byte_engine_tb_top.sv
module ow_byte_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 70, LOW1 = 6, LOW0 = 60, SMP = 15;
  localparam int BYTE_CYC = 8 * SLOT;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       ow_low, ow_in, irq;
  logic       slave_low_r = 1'b0;
  logic [7:0] slave_byte = 8'hFF;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ow_in = !(ow_low || slave_low_r);

  ow_byte_engine #(.SLOT_CYC(SLOT), .LOW1_CYC(LOW1), .LOW0_CYC(LOW0), .SAMPLE_CYC(SMP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ow_low_o(ow_low), .ow_i(ow_in), .irq_o(irq));

  // behavioural reference
  int         m_busy = 0, m_full = 0, m_cyc = 0, m_rbf = 0, m_rsrf = 0;
  logic [7:0] m_buf = '0, m_byte = '0, m_acc = '0, m_rx = '0, m_en = '0;

  function automatic bit exp_low();
    if (!m_busy) return 1'b0;
    return (m_cyc % SLOT) < (m_byte[m_cyc / SLOT] ? LOW1 : LOW0);
  endfunction

  function automatic bit exp_irq();
    logic [7:0] st;
    st = '0;
    st[2] = !m_full;
    st[3] = !m_full && !m_busy;
    st[4] = m_rbf[0];
    st[5] = m_rsrf[0];
    return |(st & m_en);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_full = 0; m_cyc = 0; m_rbf = 0; m_rsrf = 0;
      m_buf = '0; m_byte = '0; m_acc = '0; m_rx = '0; m_en = '0;
    end else begin
      int  ob, of;
      bit  bus, done;
      ob = m_busy; of = m_full; done = 0;
      bus = !(exp_low() || slave_low_r);
      if (ob != 0) begin
        if ((m_cyc % SLOT) == SMP) m_acc[m_cyc / SLOT] = bus;
        if (m_cyc == BYTE_CYC - 1) begin m_busy = 0; done = 1; end
        else m_cyc++;
      end
      if (ob == 0 && of != 0) begin
        m_byte = m_buf; m_busy = 1; m_cyc = 0; m_full = 0; m_rsrf = 0;
      end
      if (wr && addr == 2'd0 && of == 0) begin m_buf = wdata; m_full = 1; end
      if (rd && addr == 2'd0) m_rbf = 0;
      if (done) begin m_rx = m_acc; m_rbf = 1; m_rsrf = 1; end
      if (wr && addr == 2'd2) m_en = wdata & 8'h3C;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of the bus and interrupt outputs, then slave response
  always @(negedge clk) begin
    if (rst_n) begin
      check(ow_low == exp_low(), "R2 bus drive vs model", int'(ow_low), int'(exp_low()));
      check(irq == exp_irq(), "R9 irq vs model", int'(irq), int'(exp_irq()));
    end
    slave_low_r = (m_busy != 0) && !slave_byte[m_cyc / SLOT] && ((m_cyc % SLOT) < SMP + 4);
  end

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1; d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3 * BYTE_CYC; i++) begin
      @(negedge clk);
      if (m_busy == 0 && m_full == 0) break;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(ow_low == 1'b0, "R10 bus released", int'(ow_low), 0);
    check(irq == 1'b0, "R10 irq low", int'(irq), 0);
    peek(2'd1, v); check(v == 8'h0C, "R10 status", v, 8'h0C);
    peek(2'd2, v); check(v == 8'h00, "R10 enable", v, 0);
    peek(2'd0, v); check(v == 8'h00, "R10 rx byte", v, 0);

    // R9 enable mask and readback
    reg_wr(2'd2, 8'hFF);
    peek(2'd2, v); check(v == 8'h3C, "R9 enable readback masked", v, 8'h3C);
    check(irq == 1'b1, "R9 idle flags raise irq", int'(irq), 1);
    reg_wr(2'd2, 8'h00);
    check(irq == 1'b0, "R9 irq masked", int'(irq), 0);

    // R1/R2/R4/R3 write 0xA5, slave passive
    slave_byte = 8'hFF;
    reg_wr(2'd0, 8'hA5);
    peek(2'd1, v); check(v == 8'h00, "R1 tx flags cleared", v, 0);
    @(negedge clk);
    peek(2'd1, v); check(v == 8'h04, "R2 byte moved to shifter", v, 8'h04);
    check(ow_low == 1'b1, "R2 first slot low", int'(ow_low), 1);
    wait_idle();
    peek(2'd1, v); check(v == 8'h3C, "R4 flags after byte", v, 8'h3C);
    reg_rd(2'd0, v); check(v == 8'hA5, "R3 echo of written byte", v, 8'hA5);
    peek(2'd1, v); check(v == 8'h2C, "R5 read clears receive full", v, 8'h2C);

    // R3 read slot: write 0xFF, slave answers 0x3C
    slave_byte = 8'h3C;
    reg_wr(2'd0, 8'hFF);
    @(negedge clk);
    peek(2'd1, v); check(v[5] == 1'b0, "R6 ready cleared on load", v[5], 0);
    wait_idle();
    reg_rd(2'd0, v); check(v == 8'h3C, "R3 slave byte read", v, 8'h3C);

    // R3 mixed: tx 0x0F against slave 0x55
    slave_byte = 8'h55;
    reg_wr(2'd0, 8'h0F);
    wait_idle();
    reg_rd(2'd0, v); check(v == 8'h05, "R3 and of tx and slave", v, 8'h05);

    // R7/R8 queued byte and ignored write
    slave_byte = 8'hFF;
    reg_wr(2'd0, 8'h11);
    reg_wr(2'd0, 8'h22);
    peek(2'd1, v); check((v & 8'h0C) == 8'h00, "R7 buffer held", v & 8'h0C, 0);
    reg_wr(2'd0, 8'h33);
    for (int i = 0; i < BYTE_CYC; i++) @(negedge clk);
    peek(2'd1, v); check(v[2] == 1'b1, "R7 queued byte loaded", v[2], 1);
    wait_idle();
    reg_rd(2'd0, v); check(v == 8'h22, "R8 ignored byte not sent", v, 8'h22);
    peek(2'd1, v); check(v == 8'h2C, "R4 idle after queue drained", v, 8'h2C);

    // R9 receive-full interrupt
    reg_wr(2'd2, 8'h10);
    check(irq == 1'b0, "R9 no irq without flag", int'(irq), 0);
    reg_wr(2'd0, 8'h81);
    wait_idle();
    check(irq == 1'b1, "R9 irq on receive full", int'(irq), 1);
    reg_rd(2'd0, v); check(v == 8'h81, "R3 byte 0x81", v, 8'h81);
    check(irq == 1'b0, "R5 read drops irq", int'(irq), 0);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule